// File: doc/BRIEF.md
# Circulating Bit-Serial Accumulator

This block sums a sequence of serial values, each presented least significant bit first over a fixed frame of `FRAME = 2*OPW + 2` clock cycles (34 cycles for 16-bit operands). It is meant to sit behind a bit-serial multiplier and add its products into a dot product. The running total is not held in a parallel register. It lives in a ring of `FRAME` one-bit flops. A single full adder combines the incoming bit, the bit at the head of the ring and a saved carry. Its sum bit re-enters the ring at the tail on the next clock edge.

A frame starts when the frame-start marker is high with bit 0 of the new value on the serial input. The ring then rotates for exactly `FRAME` cycles. Between frames the ring holds still, so its head always carries the total's LSB and the whole total can be read in parallel. A clear input empties the ring before a new dot product. During a frame the head bit is also driven out, which gives the previous total serially, LSB first.

Top module: `bsa_accum`

## Requirements
- R1: After reset, `total_o` is zero and `total_vld_o` is 1.
- R2: A frame accepted while idle keeps `total_vld_o` low for exactly `FRAME = 2*OPW+2` clock edges (34 for OPW=16). The frame ends with `total_vld_o` high again.
- R3: Bit i of a frame value is taken from `din_i` in the i-th cycle of the frame (i = 0 first). After the frame, `total_o` equals the previous total plus the frame value, modulo 2^FRAME. Bit 0 of `total_o` is the LSB. Each sum bit enters the ring tail (bit FRAME-1) on the edge after it is formed.
- R4: The carry is zeroed on a frame's first bit, so a carry out of the MSB never reaches the next frame. Adding 1 to an all-ones total gives 0, and a following zero frame leaves it at 0.
- R5: `clr_i` empties the total, aborts any frame in progress and takes priority over `fstart_i` in the same cycle. `total_vld_o` is 1 on the next cycle.
- R6: `fstart_i` raised in the middle of a frame is ignored. Neither the result nor the frame length changes.
- R7: While idle, `din_i` has no effect and the total stays unchanged.
- R8: In cycle i of a frame, `ser_o` carries bit i of the total that stood before the frame.
- R9: A new frame may start on the cycle right after the last bit of the previous one, with no idle gap.
- R10: Signed products of two OPW-bit operands, sign-extended to FRAME bits, accumulate to their signed sum truncated to FRAME bits. This holds for up to 64 products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the total and of any frame in progress |
| fstart_i | input | 1 | High in the cycle that carries bit 0 of a new frame |
| din_i | input | 1 | Serial value, LSB first |
| ser_o | output | 1 | Ring head bit: the prior total, serially during a frame |
| total_o | output | FRAME | Parallel total, bit 0 = LSB, meaningful when `total_vld_o` is 1 |
| total_vld_o | output | 1 | High when no frame is running and the LSB is at the ring head |

## Verification
The accumulation is tried with small positive values, where a wrong bit order or misplaced tail shows at once. It is also tried with an all-ones total plus one, which separates a carry that is cleared at frame start from one that wraps into the next frame. Sequences of random signed products of random length check sign extension and truncation against plain arithmetic. Repeated extreme products (most negative times most negative, and most negative times most positive) drive the sum past the frame width. Back-to-back frames, a stray mid-frame start, idle toggling of the data input and a clear that collides with a start separate correct frame bookkeeping from a ring that drifts out of alignment.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_mode_e;

    // Ring length for a product of two opw-bit operands plus two guard bits
    function automatic int frame_bits(input int opw);
        return 2 * opw + 2;
    endfunction

endpackage

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);

    always_comb begin
        sum_o  = a_i ^ b_i ^ cin_i;
        cout_o = (a_i & b_i) | (a_i & cin_i) | (b_i & cin_i);
    end

endmodule

// File: rtl/bsa_frame_ctl.sv
module bsa_frame_ctl
    import bsa_pkg::*;
#(
    parameter int FRAME = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fstart_i,
    output logic run_o,
    output logic first_o,
    output logic idle_o
);

    localparam int PW = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

    typedef struct packed {
        ctl_mode_e     mode;
        logic [PW-1:0] ph;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    start;

    always_comb begin
        start   = (st_q.mode == CTL_IDLE) && fstart_i;
        run_o   = start || (st_q.mode == CTL_RUN);
        first_o = start;
        idle_o  = (st_q.mode == CTL_IDLE);

        st_d = st_q;
        if (clr_i) begin
            st_d.mode = CTL_IDLE;
            st_d.ph   = '0;
        end else if (start) begin
            st_d.mode = CTL_RUN;
            st_d.ph   = PW'(1);
        end else if (st_q.mode == CTL_RUN) begin
            if (st_q.ph == LAST) begin
                st_d.mode = CTL_IDLE;
                st_d.ph   = '0;
            end else begin
                st_d.ph = st_q.ph + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= CTL_IDLE;
            st_q.ph   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the phase never leaves the frame
    a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= LAST);

    // R2: the last phase of a running frame returns to idle
    a_r2_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CTL_RUN && st_q.ph == LAST && !clr_i) |=> (st_q.mode == CTL_IDLE));

    // R6: a running frame only advances by one, a marker cannot restart it
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CTL_RUN && !clr_i) |=>
            (st_q.mode == CTL_IDLE || st_q.ph == $past(st_q.ph) + PW'(1)));

    // R5: clear returns the control to idle at phase zero
    a_r5_ctl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.mode == CTL_IDLE && st_q.ph == '0));

endmodule

// File: rtl/bsa_ring.sv
module bsa_ring #(
    parameter int FRAME = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             sum_bit_i,
    output logic             head_o,
    output logic [FRAME-1:0] bits_o
);

    typedef struct packed {
        logic [FRAME-1:0] bits;
    } ring_st_t;

    ring_st_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (clr_i) begin
            ring_d.bits = '0;
        end else if (shift_i) begin
            ring_d.bits = {sum_bit_i, ring_q.bits[FRAME-1:1]};
        end
        head_o = ring_q.bits[0];
        bits_o = ring_q.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q.bits <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    // R7: an idle ring holds its contents
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clr_i) |=> $stable(ring_q.bits));

    // R5: clear empties the ring
    a_r5_ring_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ring_q.bits == '0));

    // R3: the sum bit lands at the tail one edge later, the rest moves one place toward the head
    a_r3_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=>
            (ring_q.bits[FRAME-1] == $past(sum_bit_i) &&
             ring_q.bits[FRAME-2:0] == $past(ring_q.bits[FRAME-1:1])));

endmodule

// File: rtl/bsa_accum.sv
module bsa_accum
    import bsa_pkg::*;
#(
    parameter int OPW   = 16,
    parameter int FRAME = frame_bits(OPW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fstart_i,
    input  logic             din_i,
    output logic             ser_o,
    output logic [FRAME-1:0] total_o,
    output logic             total_vld_o
);

    typedef struct packed {
        logic carry;
    } acc_st_t;

    acc_st_t acc_d, acc_q;
    logic    run, first, idle;
    logic    head, cin, sum_bit, cout;

    bsa_frame_ctl #(.FRAME(FRAME)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .fstart_i (fstart_i),
        .run_o    (run),
        .first_o  (first),
        .idle_o   (idle)
    );

    bsa_serial_adder u_add (
        .a_i    (din_i),
        .b_i    (head),
        .cin_i  (cin),
        .sum_o  (sum_bit),
        .cout_o (cout)
    );

    bsa_ring #(.FRAME(FRAME)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .shift_i   (run),
        .sum_bit_i (sum_bit),
        .head_o    (head),
        .bits_o    (total_o)
    );

    always_comb begin
        // Fresh carry on bit 0: no wrap from the previous frame's MSB
        cin   = first ? 1'b0 : acc_q.carry;
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.carry = 1'b0;
        end else if (run) begin
            acc_d.carry = cout;
        end
        ser_o       = head;
        total_vld_o = idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.carry <= 1'b0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R4: the first bit of a frame is added without any carry
    a_r4_fresh_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !clr_i) |=> (total_o[FRAME-1] == $past(din_i ^ ser_o)));

    // R2: valid only drops when a frame is accepted
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(total_vld_o) |-> $past(fstart_i && !clr_i));

    // R5: clear wins over a start in the same cycle
    a_r5_clr_priority: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> total_vld_o);

endmodule

// File: tb/bsa_accum_test.sv
`timescale 1ns/1ps
module bsa_accum_test;

    localparam int OPW   = 16;
    localparam int FRAME = 2 * OPW + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             fstart = 1'b0;
    logic             din = 1'b0;
    logic             ser;
    logic             vld;
    logic [FRAME-1:0] total;

    int errs = 0;
    int nchk = 0;
    bit done = 1'b0;

    logic [FRAME-1:0] seen;
    logic             last_vld;

    always #10 clk = ~clk;

    bsa_accum #(.OPW(OPW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .fstart_i    (fstart),
        .din_i       (din),
        .ser_o       (ser),
        .total_o     (total),
        .total_vld_o (vld)
    );

    task automatic chk(input string tag, input logic [FRAME-1:0] act, input logic [FRAME-1:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [FRAME-1:0] prod_frame(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        logic signed [2*OPW-1:0] p;
        p = $signed(a) * $signed(b);
        return {{(FRAME-2*OPW){p[2*OPW-1]}}, p};
    endfunction

    // Caller stands just after a falling edge; returns just after a falling edge.
    task automatic frame(input logic [FRAME-1:0] v, input int glitch);
        for (int i = 0; i < FRAME; i++) begin
            fstart = (i == 0) || (i == glitch);
            din    = v[i];
            seen[i] = ser;
            if (i == FRAME - 1) last_vld = vld;
            @(negedge clk);
        end
        fstart = 1'b0;
        din    = 1'b0;
    endtask

    task automatic do_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        logic [FRAME-1:0] exp;
        logic [FRAME-1:0] pv;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset total", total, '0);
        chk("R1 reset valid", FRAME'(vld), FRAME'(1));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 plain add, R2 frame length
        frame(FRAME'(5), -1);
        chk("R2 valid low on last bit", FRAME'(last_vld), '0);
        chk("R2 valid after frame", FRAME'(vld), FRAME'(1));
        chk("R3 total 0+5", total, FRAME'(5));

        // R9 back-to-back, R8 serial view of old total
        frame(FRAME'(3), -1);
        chk("R9 back-to-back total", total, FRAME'(8));
        chk("R8 serial prior total", seen, FRAME'(5));

        // R6 stray marker in mid-frame
        frame(FRAME'(10), 17);
        chk("R6 mid-frame marker total", total, FRAME'(18));
        chk("R6 frame length kept", FRAME'(vld), FRAME'(1));

        // R7 idle data ignored
        din = 1'b1;
        repeat (20) @(negedge clk);
        din = 1'b0;
        chk("R7 idle din ignored", total, FRAME'(18));
        chk("R7 still valid", FRAME'(vld), FRAME'(1));

        // R4 carry out of MSB must not wrap
        do_clr();
        chk("R5 clear total", total, '0);
        frame('1, -1);
        chk("R4 all ones", total, '1);
        frame(FRAME'(1), -1);
        chk("R4 ones plus one", total, '0);
        frame('0, -1);
        chk("R4 no carry wrap", total, '0);

        // R5 clear aborts a frame and beats a start in the same cycle
        frame(FRAME'(9), -1);
        fstart = 1'b1; din = 1'b1;
        @(negedge clk);
        fstart = 1'b0;
        repeat (5) @(negedge clk);
        clr = 1'b1; fstart = 1'b1;
        @(negedge clk);
        clr = 1'b0; fstart = 1'b0; din = 1'b0;
        chk("R5 abort total", total, '0);
        chk("R5 clear beats start", FRAME'(vld), FRAME'(1));
        @(negedge clk);
        chk("R5 stays idle", FRAME'(vld), FRAME'(1));
        frame(FRAME'(7), -1);
        chk("R5 clean frame after clear", total, FRAME'(7));

        // R10 directed extremes and random signed dot products
        for (int run = 0; run < 6; run++) begin
            int len;
            len = (run < 2) ? 64 : 1 + int'($urandom % 64);
            do_clr();
            exp = '0;
            for (int k = 0; k < len; k++) begin
                logic [OPW-1:0] a;
                logic [OPW-1:0] b;
                if (run == 0) begin
                    a = {1'b1, {(OPW-1){1'b0}}};
                    b = a;
                end else if (run == 1) begin
                    a = {1'b1, {(OPW-1){1'b0}}};
                    b = {1'b0, {(OPW-1){1'b1}}};
                end else begin
                    a = OPW'($urandom);
                    b = OPW'($urandom);
                end
                pv  = prod_frame(a, b);
                exp = exp + pv;
                frame(pv, -1);
            end
            chk($sformatf("R10 dot product run %0d len %0d", run, len), total, exp);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

endmodule